// File: doc/BRIEF.md
# Character Serial Port Register Front End

This block sits between a 32-bit bus slave port and the byte streams of a serial port. It holds two byte queues. One collects characters arriving from the serial receiver. The other holds characters waiting to be sent by the serial transmitter. Software reaches it through two word offsets. Offset +0 is a data window whose meaning depends on direction: a write queues a character for transmission, and a read takes the oldest received character. Offset +4 is a control/status word. It reports free transmit space and holds the interrupt enables and pending flags.

A receive read is a single atomic operation. The returned word carries the character, a flag telling whether the character is real, and the number of characters still queued behind it. The queue pops on the same clock edge that ends the read. The returned word is driven combinationally while the read strobe is high.

The receive stream never back-pressures: `rx_ready` stays high. A byte that arrives when the receive queue is full is discarded. The transmit stream presents the oldest queued byte with `tx_valid`. That byte leaves on the first rising edge where `tx_valid` and `tx_ready` are both high, and until then it is held steady.

Top module: `char_port_regs`

## Requirements
- R1: A bus write at offset 0 queues `bus_wdata[7:0]` for transmission. Queued bytes appear on `tx_data` in write order, and `tx_valid` is high exactly while the transmit queue holds at least one byte.
- R2: A bus read at offset 0 while the receive queue is non-empty returns, in the same cycle, the oldest byte in bits 7:0, a 1 in bit 15, zeros in bits 14:8, and in bits 31:16 the count of bytes left after this one. The byte is removed on the clock edge that ends the read.
- R3: A bus read at offset 0 while the receive queue is empty returns an all-zero word (bit 15 is 0) and leaves the queue unchanged.
- R4: Bits 31:16 of the word at offset 4 equal the transmit depth minus the number of queued transmit bytes. A data write while this value is 0 and no byte leaves in the same cycle is discarded.
- R5: `rx_ready` is always high. A byte offered on `rx_valid` is stored unless the receive queue is full. A byte offered while the queue is full is lost, unless a data read pops the queue on that same edge, in which case the byte is stored.
- R6: A bus write at offset 4 loads bit 0 (receive-interrupt enable) and bit 1 (transmit-interrupt enable) from `bus_wdata`. In the word read at offset 4, these appear at bits 0 and 1, and bits 15:10 and 7:2 read as 0.
- R7: Bit 8 at offset 4 is the receive enable AND "receive queue non-empty". Bit 9 is the transmit enable AND "transmit free count non-zero". `irq` is the OR of bits 8 and 9.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values. Each handshake removes exactly one byte.
- R9: After reset, both queues are empty, both enables are clear, the word at offset 4 reads as the transmit depth in bits 31:16 with all other bits 0, and `tx_valid` and `irq` are low.
- R10: Bus reads at any offset other than 0 and 4 return 0 and pop nothing. Bus writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read strobe is high, 0 otherwise |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Always 1; overflow bytes are dropped |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Oldest queued transmit byte |

## Verification
Read data is due in the same cycle as its strobe, so the bench drives each access just after a falling edge and samples `bus_rdata` one nanosecond later, before the rising edge that performs the pop. Queue occupancy, enables, the pending flags and `irq` change on the rising edge that ends an access or stream handshake. They are therefore sampled one nanosecond after that edge, or through the next read. Transmit bytes are checked while `tx_ready` is held high and before the edge that consumes them, so that each check sees the byte the handshake is about to remove.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
package cpr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_LSB  = 16;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_CTRL = 4;
  localparam int unsigned B_RX_EN  = 0;
  localparam int unsigned B_TX_EN  = 1;
  localparam int unsigned B_RX_PND = 8;
  localparam int unsigned B_TX_PND = 9;
  localparam int unsigned B_VALID  = 15;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DATA = 2'd1,
    TGT_CTRL = 2'd2
  } target_e;
endpackage

// File: rtl/cpr_fifo.sv
`timescale 1ns/1ps
module cpr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             pop_ok, push_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cpr_ctrl.sv
`timescale 1ns/1ps
module cpr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [1:0] en_in,
  input  logic       rx_any,
  input  logic       tx_room,
  output logic       rx_en,
  output logic       tx_en,
  output logic       rx_pnd,
  output logic       tx_pnd,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (ctrl_we) begin
      rx_en <= en_in[0];
      tx_en <= en_in[1];
    end
  end

  assign rx_pnd = rx_en && rx_any;
  assign tx_pnd = tx_en && tx_room;
  assign irq    = rx_pnd || tx_pnd;
endmodule

// File: rtl/char_port_regs.sv
`timescale 1ns/1ps
module char_port_regs
  import cpr_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);

  target_e               tgt;
  logic                  rd_stb, wr_stb;
  logic                  rx_pop, rx_full, rx_empty;
  logic [RCW-1:0]        rx_count;
  logic [BYTE_W-1:0]     rx_head;
  logic                  tx_push, tx_pop, tx_full, tx_empty;
  logic [TCW-1:0]        tx_count;
  logic [CNT_W-1:0]      rx_left, tx_free;
  logic                  rx_en, tx_en, rx_pnd, tx_pnd;
  logic                  unused_wbits;

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_DATA))      tgt = TGT_DATA;
    else if (bus_addr == ADDR_W'(OFF_CTRL)) tgt = TGT_CTRL;
    else                                    tgt = TGT_NONE;
  end

  assign rd_stb  = bus_sel && !bus_wr;
  assign wr_stb  = bus_sel && bus_wr;
  assign rx_pop  = rd_stb && (tgt == TGT_DATA) && !rx_empty;
  assign tx_push = wr_stb && (tgt == TGT_DATA);
  assign tx_pop  = tx_valid && tx_ready;

  assign rx_ready = 1'b1;
  assign tx_valid = !tx_empty;
  assign unused_wbits = ^{bus_wdata[31:8], rx_full, tx_full};

  cpr_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .din(rx_data), .pop(rx_pop), .dout(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  cpr_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  assign rx_left = CNT_W'(rx_count) - CNT_W'(1);
  assign tx_free = CNT_W'(TX_DEPTH) - CNT_W'(tx_count);

  cpr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr_stb && (tgt == TGT_CTRL)), .en_in(bus_wdata[1:0]),
    .rx_any(!rx_empty), .tx_room(tx_free != '0),
    .rx_en(rx_en), .tx_en(tx_en), .rx_pnd(rx_pnd), .tx_pnd(tx_pnd),
    .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (tgt)
        TGT_DATA: if (!rx_empty) begin
          bus_rdata[CNT_LSB +: CNT_W]  = rx_left;
          bus_rdata[B_VALID]           = 1'b1;
          bus_rdata[BYTE_W-1:0]        = rx_head;
        end
        TGT_CTRL: begin
          bus_rdata[CNT_LSB +: CNT_W] = tx_free;
          bus_rdata[B_TX_PND]         = tx_pnd;
          bus_rdata[B_RX_PND]         = rx_pnd;
          bus_rdata[B_TX_EN]          = tx_en;
          bus_rdata[B_RX_EN]          = rx_en;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpr_checker.sv
`timescale 1ns/1ps
module cpr_checker #(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data
);
  logic rd_data, rd_ctrl, rd_other;
  assign rd_data  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(0));
  assign rd_ctrl  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(4));
  assign rd_other = bus_sel && !bus_wr && !rd_data && !rd_ctrl;

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !bus_rdata[15]) |-> (bus_rdata == 32'd0));

  p_left_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && bus_rdata[15]) |-> (bus_rdata[31:16] < 16'(RX_DEPTH) && bus_rdata[14:8] == 7'd0));

  p_free_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (bus_rdata[31:16] <= 16'(TX_DEPTH)));

  p_ctrl_zero_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (bus_rdata[15:10] == 6'd0 && bus_rdata[7:2] == 6'd0));

  p_irq_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (irq == (bus_rdata[8] || bus_rdata[9])));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |-> (bus_rdata == 32'd0));

  p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == 32'd0));
endmodule

bind char_port_regs cpr_checker #(
  .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .ADDR_W(ADDR_W)
) u_cpr_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/tb_char_port_regs.sv
`timescale 1ns/1ps
module tb_char_port_regs;
  localparam int RXD = 4;
  localparam int TXD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rx_ready, tx_valid;
  logic        rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_data;

  int  vectors = 0, errors = 0;
  bit  done = 1'b0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [1:0] en_m = 2'b00;

  always #2.5 clk = ~clk;

  char_port_regs #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .ADDR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data();
    if (rxq.size() == 0) return 32'd0;
    return {16'(rxq.size() - 1), 1'b1, 7'd0, rxq[0]};
  endfunction

  function automatic logic exp_irq();
    return (en_m[0] && rxq.size() > 0) || (en_m[1] && txq.size() < TXD);
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic rp, wp;
    rp = en_m[0] && rxq.size() > 0;
    wp = en_m[1] && txq.size() < TXD;
    return {16'(TXD - txq.size()), 6'd0, wp, rp, 6'd0, en_m};
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 3'd0 && txq.size() < TXD) txq.push_back(d[7:0]);
    if (a == 3'd4) en_m = d[1:0];
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    if (a == 3'd0 && rxq.size() > 0) void'(rxq.pop_front());
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (rxq.size() < RXD) rxq.push_back(b);
  endtask

  task automatic tx_take(input string tag);
    @(negedge clk);
    tx_ready = 1'b1;
    #1;
    chk({tag, " tx_valid"}, 32'(tx_valid), 32'd1);
    chk({tag, " tx_data"}, 32'(tx_data), 32'(txq[0]));
    @(posedge clk); #1;
    tx_ready = 1'b0;
    void'(txq.pop_front());
  endtask

  task automatic check_ctrl(input string tag);
    logic [31:0] d, e;
    e = exp_ctrl();
    bus_read(3'd4, d);
    chk(tag, d, e);
  endtask

  task automatic check_data(input string tag);
    logic [31:0] d, e;
    e = exp_data();
    bus_read(3'd0, d);
    chk(tag, d, e);
  endtask

  task automatic flush_all();
    while (rxq.size() > 0) check_data("R2 flush");
    while (txq.size() > 0) tx_take("R1 flush");
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  hold;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state
    #1;
    chk("R9 tx_valid", 32'(tx_valid), 32'd0);
    chk("R9 irq", 32'(irq), 32'd0);
    chk("R5 rx_ready", 32'(rx_ready), 32'd1);
    check_ctrl("R9 ctrl word");
    check_data("R3 empty read after reset");

    // R1 and R4: fill the transmit queue past its depth
    for (int n = 0; n <= TXD; n++) begin
      bus_write(3'd0, 32'hFFFF_FF00 | 32'(8'h30 + n));
      check_ctrl("R4 free count");
      chk("R1 tx_valid", 32'(tx_valid), 32'd1);
      chk("R1 head", 32'(tx_data), 32'h30);
    end
    // R8: held under back-pressure
    hold = tx_data;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R8 hold valid", 32'(tx_valid), 32'd1);
      chk("R8 hold data", 32'(tx_data), 32'(hold));
    end
    while (txq.size() > 0) tx_take("R1 drain");
    #1 chk("R1 empty tx_valid", 32'(tx_valid), 32'd0);

    // R1: several lengths and byte patterns
    for (int len = 1; len <= TXD; len++) begin
      for (int i = 0; i < len; i++) bus_write(3'd0, 32'((len * 37 + i * 11) & 8'hFF));
      check_ctrl("R4 partial");
      while (txq.size() > 0) tx_take("R1 pattern");
      #1 chk("R8 one per handshake", 32'(tx_valid), 32'd0);
    end

    // R2, R3, R5: receive sweep over fill levels including overflow
    for (int k = 0; k <= RXD + 2; k++) begin
      for (int i = 0; i < k; i++) rx_push(8'(8'h80 + k * 8 + i));
      for (int i = 0; i <= k && i <= RXD; i++) check_data("R2 read sweep");
      check_data("R3 empty after sweep");
    end

    // R5: arrival on a full queue in the same cycle as a pop
    for (int i = 0; i < RXD; i++) rx_push(8'(8'hC0 + i));
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
    rx_valid = 1'b1; rx_data = 8'hEE;
    #1 chk("R2 read during push", bus_rdata, exp_data());
    @(posedge clk); #1;
    bus_sel = 1'b0; rx_valid = 1'b0;
    void'(rxq.pop_front());
    rxq.push_back(8'hEE);
    while (rxq.size() > 0) check_data("R5 order after pop+push");
    check_data("R3 empty again");

    // R6, R7: enables against queue states
    for (int en = 0; en < 4; en++) begin
      for (int rf = 0; rf < 2; rf++) begin
        for (int tf = 0; tf < 2; tf++) begin
          if (rf == 1) rx_push(8'h5A);
          if (tf == 1) for (int i = 0; i < TXD; i++) bus_write(3'd0, 32'(i));
          bus_write(3'd4, 32'hFFFF_FFFC | 32'(en));
          check_ctrl("R6 R7 ctrl word");
          chk("R7 irq", 32'(irq), 32'(exp_irq()));
          flush_all();
          chk("R7 irq after flush", 32'(irq), 32'(exp_irq()));
        end
      end
    end

    // R10: unmapped offsets
    bus_write(3'd4, 32'd0);
    bus_write(3'd2, 32'h3);
    bus_write(3'd6, 32'h41);
    check_ctrl("R10 writes ignored");
    #1 chk("R10 no tx push", 32'(tx_valid), 32'd0);
    rx_push(8'h77);
    bus_read(3'd1, d); chk("R10 read off 1", d, 32'd0);
    bus_read(3'd5, d); chk("R10 read off 5", d, 32'd0);
    check_data("R10 no pop by unmapped read");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule